// File: doc/BRIEF.md
# Skip-Based Clock Compensation Buffer

This block is a dual-clock elastic FIFO for a serial link receive path. It carries 10-bit line symbols. Symbols are written on the clock recovered from the incoming bit stream and are read out on the local transmit clock. Each of the two clocks may be off nominal by up to 100 ppm, so the two can drift apart by 200 ppm, which is about one symbol of slip every 5000 clocks. The buffer absorbs that slip. Packet symbols are never touched. The fill level changes only through the filler symbols that follow a comma inside a Skip ordered set. When the buffer runs too full, the write side drops one of these filler symbols. When it runs too empty, the read side presents one of them twice.

Reading starts only after the buffer has been primed to a start level. The symbol pointers cross between the two clock domains as gray codes through two-flop synchronisers. A comma is recognised in either running-disparity form. The filler symbol is matched against a pair of 10-bit codes given as parameters, one code for each disparity. If the buffer ever overflows, or runs dry after priming, symbols are lost. In that case a link error is raised and held until reset, so that link recovery can be started.

Top module: `skp_elastic_buf`

## Requirements
- R1: While reset is applied and right after it is released, `rdValid` and `linkErr` are both 0.
- R2: No symbol is presented (`rdValid` stays 0) until the read-side fill level has reached `START_LVL` at least once since reset.
- R3: Every symbol that is not a filler symbol (commas and packet data included) appears on `rdSym` exactly once, in the order it was written, as long as neither overflow nor underflow occurs.
- R4: When the write-side fill level is above `HI_WM`, the write side discards at most one filler symbol per Skip set. It discards one only if a filler symbol of that same set has already been stored, so every set keeps at least one filler symbol after its comma.
- R5: When the read-side fill level is below `LO_WM` and the head symbol is a filler symbol inside a Skip set, that symbol is presented for two consecutive cycles and the read pointer does not advance in the first of them. This happens at most once per set.
- R6: A comma is either 10'b0011111010 or 10'b1100000101, and either form opens a Skip set. A filler symbol is `SKP_A` (default 10'b0011110100) or `SKP_B` (default 10'b1100001011).
- R7: After priming, a read cycle that finds the buffer empty is an underflow. It sets `linkErr`, and `rdValid` is 0 in that cycle.
- R8: A write that arrives while the buffer holds `DEPTH` symbols, and that is not a discard, is lost and sets `linkErr`. `linkErr` is brought into the read domain through two flops.
- R9: Once `linkErr` is 1, it stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Recovered receive clock (write domain) |
| rdClk | input | 1 | Local transmit clock (read domain) |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| wrValid | input | 1 | `wrSym` carries a symbol in this write cycle |
| wrSym | input | 10 | Incoming 10-bit symbol |
| rdValid | output | 1 | `rdSym` carries a symbol in this read cycle |
| rdSym | output | 10 | Outgoing 10-bit symbol |
| linkErr | output | 1 | Sticky overflow or underflow indication |

## Verification
The bench builds the block with its default parameters: `DEPTH` 16, `HI_WM` 12, `LO_WM` 4 and `START_LVL` 8. The read clock is held at its nominal rate. The write clock is run 5% slow in one phase and 5% fast in another, far beyond the real 200 ppm offset. With that much slip, several dozen insertions and deletions happen within a few hundred symbols, and the fill level reaches both watermarks. The Skip sets alternate between the two comma polarities, so shortened and lengthened sets are seen under each one. A final phase with the write clock at twice the rate, and with no filler symbols to drop, forces an overflow. The drain at the end of the slow phase forces an underflow.

// File: rtl/eb_pkg.sv
`timescale 1ns/1ps
package eb_pkg;
  localparam int SYM_W = 10;
  localparam logic [SYM_W-1:0] COM_NEG = 10'b0011111010;
  localparam logic [SYM_W-1:0] COM_POS = 10'b1100000101;

  typedef struct packed {
    logic wrPush;
    logic rdPop;
  } ebStrobe_t;

  function automatic logic isComma(input logic [SYM_W-1:0] s);
    return (s == COM_NEG) || (s == COM_POS);
  endfunction
endpackage

// File: rtl/eb_datapath.sv
`timescale 1ns/1ps
module eb_datapath
  import eb_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int SYNC_STAGES = 2,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic             wrClk,
  input  logic             rdClk,
  input  logic             rstN,
  input  ebStrobe_t        strobe,
  input  logic [SYM_W-1:0] wrSym,
  output logic [PW-1:0]    wrFill,
  output logic [PW-1:0]    rdFill,
  output logic [SYM_W-1:0] headSym
);
  logic [SYM_W-1:0] store [DEPTH];
  logic [PW-1:0] wrBin, rdBin, wrGray, rdGray;
  logic [PW-1:0] wrBinNext, rdBinNext;
  logic [PW-1:0] rdGraySync [SYNC_STAGES];
  logic [PW-1:0] wrGraySync [SYNC_STAGES];

  function automatic logic [PW-1:0] grayToBin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  assign wrBinNext = wrBin + PW'(1);
  assign rdBinNext = rdBin + PW'(1);

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wrBin  <= '0;
      wrGray <= '0;
    end else if (strobe.wrPush) begin
      wrBin  <= wrBinNext;
      wrGray <= wrBinNext ^ (wrBinNext >> 1);
    end
  end

  always_ff @(posedge wrClk) begin
    if (strobe.wrPush) store[wrBin[AW-1:0]] <= wrSym;
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdBin  <= '0;
      rdGray <= '0;
    end else if (strobe.rdPop) begin
      rdBin  <= rdBinNext;
      rdGray <= rdBinNext ^ (rdBinNext >> 1);
    end
  end

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge wrClk or negedge rstN) begin
        if (!rstN) rdGraySync[s] <= '0;
        else rdGraySync[s] <= (s == 0) ? rdGray : rdGraySync[(s == 0) ? 0 : s - 1];
      end
      always_ff @(posedge rdClk or negedge rstN) begin
        if (!rstN) wrGraySync[s] <= '0;
        else wrGraySync[s] <= (s == 0) ? wrGray : wrGraySync[(s == 0) ? 0 : s - 1];
      end
    end
  endgenerate

  assign wrFill  = wrBin - grayToBin(rdGraySync[SYNC_STAGES-1]);
  assign rdFill  = grayToBin(wrGraySync[SYNC_STAGES-1]) - rdBin;
  assign headSym = store[rdBin[AW-1:0]];
endmodule

// File: rtl/eb_control.sv
`timescale 1ns/1ps
module eb_control
  import eb_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int HI_WM = 12,
  parameter int LO_WM = 4,
  parameter int START_LVL = 8,
  parameter logic [SYM_W-1:0] SKP_A = 10'b0011110100,
  parameter logic [SYM_W-1:0] SKP_B = 10'b1100001011,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic             wrClk,
  input  logic             rdClk,
  input  logic             rstN,
  input  logic             wrValid,
  input  logic [SYM_W-1:0] wrSym,
  input  logic [PW-1:0]    wrFill,
  input  logic [PW-1:0]    rdFill,
  input  logic [SYM_W-1:0] headSym,
  output ebStrobe_t        strobe,
  output logic             wrDrop,
  output logic             rdHold,
  output logic             rdValid,
  output logic [SYM_W-1:0] rdSym,
  output logic             linkErr
);
  function automatic logic isFiller(input logic [SYM_W-1:0] s);
    return (s == SKP_A) || (s == SKP_B);
  endfunction

  // write domain
  logic wrInSet, wrKept, wrDropped, wrFull, wrOvf;
  logic wrIsCom, wrIsSkp;

  assign wrIsCom = isComma(wrSym);
  assign wrIsSkp = isFiller(wrSym);
  assign wrFull  = (wrFill == PW'(DEPTH));
  assign wrDrop  = wrValid && wrIsSkp && wrInSet && wrKept && !wrDropped
                   && (wrFill > PW'(HI_WM));
  assign strobe.wrPush = wrValid && !wrDrop && !wrFull;

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wrInSet   <= 1'b0;
      wrKept    <= 1'b0;
      wrDropped <= 1'b0;
      wrOvf     <= 1'b0;
    end else begin
      if (wrValid) begin
        if (wrIsCom) begin
          wrInSet   <= 1'b1;
          wrKept    <= 1'b0;
          wrDropped <= 1'b0;
        end else if (wrIsSkp) begin
          if (wrDrop) wrDropped <= 1'b1;
          else if (!wrFull) wrKept <= 1'b1;
        end else begin
          wrInSet <= 1'b0;
        end
        if (!wrDrop && wrFull) wrOvf <= 1'b1;
      end
    end
  end

  // read domain
  logic primed, rdEmpty, rdInSet, rdInserted, underErr, ovfMeta, ovfSeen;

  assign rdEmpty = (rdFill == '0);
  assign rdValid = primed && !rdEmpty;
  assign rdSym   = headSym;
  assign rdHold  = rdValid && isFiller(headSym) && rdInSet && !rdInserted
                   && (rdFill < PW'(LO_WM));
  assign strobe.rdPop = rdValid && !rdHold;
  assign linkErr = underErr || ovfSeen;

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      primed     <= 1'b0;
      rdInSet    <= 1'b0;
      rdInserted <= 1'b0;
      underErr   <= 1'b0;
      ovfMeta    <= 1'b0;
      ovfSeen    <= 1'b0;
    end else begin
      ovfMeta <= wrOvf;
      ovfSeen <= ovfMeta;
      if (!primed && (rdFill >= PW'(START_LVL))) primed <= 1'b1;
      if (primed && rdEmpty) underErr <= 1'b1;
      if (rdValid) begin
        if (isComma(headSym)) begin
          rdInSet    <= 1'b1;
          rdInserted <= 1'b0;
        end else if (isFiller(headSym)) begin
          if (rdHold) rdInserted <= 1'b1;
        end else begin
          rdInSet <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/skp_elastic_buf.sv
`timescale 1ns/1ps
module skp_elastic_buf
  import eb_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int HI_WM = 12,
  parameter int LO_WM = 4,
  parameter int START_LVL = 8,
  parameter logic [9:0] SKP_A = 10'b0011110100,
  parameter logic [9:0] SKP_B = 10'b1100001011
) (
  input  logic       wrClk,
  input  logic       rdClk,
  input  logic       rstN,
  input  logic       wrValid,
  input  logic [9:0] wrSym,
  output logic       rdValid,
  output logic [9:0] rdSym,
  output logic       linkErr
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  ebStrobe_t strobe;
  logic [PW-1:0] wrFill, rdFill;
  logic [9:0] headSym;
  logic wrDrop, rdHold;

  eb_datapath #(.DEPTH(DEPTH)) u_dp (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .strobe(strobe),
    .wrSym(wrSym), .wrFill(wrFill), .rdFill(rdFill), .headSym(headSym)
  );

  eb_control #(
    .DEPTH(DEPTH), .HI_WM(HI_WM), .LO_WM(LO_WM), .START_LVL(START_LVL),
    .SKP_A(SKP_A), .SKP_B(SKP_B)
  ) u_ctl (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .wrValid(wrValid),
    .wrSym(wrSym), .wrFill(wrFill), .rdFill(rdFill), .headSym(headSym),
    .strobe(strobe), .wrDrop(wrDrop), .rdHold(rdHold), .rdValid(rdValid),
    .rdSym(rdSym), .linkErr(linkErr)
  );
endmodule

// File: rtl/eb_checker.sv
`timescale 1ns/1ps
module eb_checker #(
  parameter int DEPTH = 16,
  parameter int PW = 5
) (
  input logic          wrClk,
  input logic          rdClk,
  input logic          rstN,
  input logic          wrDrop,
  input logic          rdHold,
  input logic          rdValid,
  input logic [9:0]    rdSym,
  input logic          linkErr,
  input logic          wrPush,
  input logic          rdPop,
  input logic [PW-1:0] wrFill,
  input logic [PW-1:0] rdFill
);
  p_single_drop_r4: assert property (@(posedge wrClk) disable iff (!rstN)
    wrDrop |=> !wrDrop);
  p_hold_repeats_r5: assert property (@(posedge rdClk) disable iff (!rstN)
    rdHold |=> (!rdValid || $stable(rdSym)));
  p_single_hold_r5: assert property (@(posedge rdClk) disable iff (!rstN)
    rdHold |=> !rdHold);
  p_no_pop_empty_r7: assert property (@(posedge rdClk) disable iff (!rstN)
    (rdFill == '0) |-> !rdPop);
  p_no_overflow_r8: assert property (@(posedge wrClk) disable iff (!rstN)
    (wrFill == PW'(DEPTH)) |-> !wrPush);
  p_err_sticky_r9: assert property (@(posedge rdClk) disable iff (!rstN)
    linkErr |=> linkErr);
endmodule

bind skp_elastic_buf eb_checker #(.DEPTH(DEPTH), .PW(PW)) u_chk (
  .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .wrDrop(wrDrop),
  .rdHold(rdHold), .rdValid(rdValid), .rdSym(rdSym), .linkErr(linkErr),
  .wrPush(strobe.wrPush), .rdPop(strobe.rdPop), .wrFill(wrFill),
  .rdFill(rdFill)
);

// File: tb/sim_skp_elastic_buf.sv
`timescale 1ns/1ps
module sim_skp_elastic_buf;
  localparam logic [9:0] SKP_A = 10'b0011110100;
  localparam logic [9:0] SKP_B = 10'b1100001011;
  localparam logic [9:0] COM_N = 10'b0011111010;
  localparam logic [9:0] COM_P = 10'b1100000101;

  logic wrClk = 1'b0, rdClk = 1'b0, rstN = 1'b0, wrValid = 1'b0;
  logic [9:0] wrSym = '0;
  logic rdValid, linkErr;
  logic [9:0] rdSym;
  real wrHalf = 4.0;

  int vectors = 0, miscompares = 0;
  int inSkp = 0, outSkp = 0, dataCnt = 0;
  int shortP = 0, shortN = 0, longP = 0, longN = 0;
  bit monOn = 1'b1, setOpen = 1'b0, setPos = 1'b0, done = 1'b0;
  int setSkp = 0;
  logic [9:0] expQ[$];

  always #4 rdClk = ~rdClk;
  always #(wrHalf) wrClk = ~wrClk;

  skp_elastic_buf u0 (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .wrValid(wrValid),
    .wrSym(wrSym), .rdValid(rdValid), .rdSym(rdSym), .linkErr(linkErr)
  );

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit isSkp(input logic [9:0] s);
    return (s == SKP_A) || (s == SKP_B);
  endfunction

  function automatic void closeSet();
    if (setOpen) begin
      if (setSkp == 0) begin
        vectors++; miscompares++;
        $display("FAIL R4: set kept %0d fillers expected at least 1", setSkp);
      end
      if (setSkp < 3) begin if (setPos) shortP++; else shortN++; end
      if (setSkp > 3) begin if (setPos) longP++; else longN++; end
    end
  endfunction

  // monitor / scoreboard
  always @(negedge rdClk) begin
    if (rstN && rdValid && monOn) begin
      if (isSkp(rdSym)) begin
        outSkp++; setSkp++;
      end else begin
        logic [9:0] exp;
        closeSet();
        setOpen = (rdSym == COM_N) || (rdSym == COM_P);
        setPos = (rdSym == COM_P);
        setSkp = 0;
        vectors++;
        if (expQ.size() == 0) begin
          miscompares++;
          $display("FAIL R3: actual %h expected nothing", rdSym);
        end else begin
          exp = expQ.pop_front();
          if (exp != rdSym) begin
            miscompares++;
            $display("FAIL R3: actual %h expected %h", rdSym, exp);
          end
        end
      end
    end
  end

  task automatic sendSym(input logic [9:0] s, input bit track);
    @(negedge wrClk);
    wrValid = 1'b1;
    wrSym = s;
    if (track) begin
      if (isSkp(s)) inSkp++;
      else expQ.push_back(s);
    end
  endtask

  task automatic idleWr();
    @(negedge wrClk);
    wrValid = 1'b0;
  endtask

  task automatic sendData(input int n, input bit track);
    for (int i = 0; i < n; i++) begin
      sendSym(10'h200 | 10'(dataCnt & 8'hFF), track);
      dataCnt++;
    end
  endtask

  task automatic sendSets(input int n);
    for (int i = 0; i < n; i++) begin
      sendSym((i % 2) ? COM_P : COM_N, 1'b1);
      for (int k = 0; k < 3; k++) sendSym((k % 2) ? SKP_B : SKP_A, 1'b1);
      sendData(8, 1'b1);
    end
    idleWr();
  endtask

  task automatic rdWait(input int n);
    for (int i = 0; i < n; i++) @(negedge rdClk);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    wrValid = 1'b0;
    rdWait(4);
    expQ.delete();
    inSkp = 0; outSkp = 0; setOpen = 0; setSkp = 0;
    shortP = 0; shortN = 0; longP = 0; longN = 0;
    #1.3 rstN = 1'b1;
    rdWait(1);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      vectors++; miscompares++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rdWait(3);
    check("R1 rdValid in reset", int'(rdValid), 0);
    check("R1 linkErr in reset", int'(linkErr), 0);
    #1.3 rstN = 1'b1;
    rdWait(2);
    check("R1 rdValid after reset", int'(rdValid), 0);
    check("R1 linkErr after reset", int'(linkErr), 0);

    // R2: below the start level nothing is presented
    sendData(3, 1'b1);
    idleWr();
    rdWait(20);
    check("R2 rdValid before priming", int'(rdValid), 0);
    check("R2 no underflow before priming", int'(linkErr), 0);

    // slow write clock: insertion phase
    wrHalf = 4.2;
    sendSets(40);
    check("R5 no error during slow stream", int'(linkErr), 0);
    rdWait(40);
    closeSet(); setOpen = 0;
    check("R3 all symbols delivered (slow)", expQ.size(), 0);
    check("R5 fillers added", int'(outSkp > inSkp), 1);
    check("R6 lengthened set after positive comma", int'(longP > 0), 1);
    check("R6 lengthened set after negative comma", int'(longN > 0), 1);
    check("R7 underflow raises linkErr", int'(linkErr), 1);
    check("R7 rdValid low when empty", int'(rdValid), 0);
    rdWait(50);
    check("R9 linkErr held", int'(linkErr), 1);

    // fast write clock: deletion phase
    doReset();
    check("R9 linkErr cleared by reset", int'(linkErr), 0);
    wrHalf = 3.8;
    sendSets(40);
    check("R4 no error during fast stream", int'(linkErr), 0);
    rdWait(40);
    closeSet(); setOpen = 0;
    check("R3 all symbols delivered (fast)", expQ.size(), 0);
    check("R4 fillers removed", int'(outSkp < inSkp), 1);
    check("R6 shortened set after positive comma", int'(shortP > 0), 1);
    check("R6 shortened set after negative comma", int'(shortN > 0), 1);

    // overflow phase: packet data only, twice the read rate
    doReset();
    monOn = 1'b0;
    wrHalf = 2.0;
    sendData(120, 1'b0);
    idleWr();
    rdWait(3);
    check("R8 overflow raises linkErr", int'(linkErr), 1);
    rdWait(40);
    check("R9 linkErr held after overflow", int'(linkErr), 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule